// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block takes a configuration image from a host and hands it, one 32-bit word at a time, to the configuration port of downstream programmable devices. The host works through a small register window. It first sets the expected image length in bytes while the engine is off. It then switches the engine on, in either host-feed or DMA-feed mode, and pushes data words into a write-only FIFO window. The loader drains the FIFO into a ready/valid word sink and adds four bytes to a running count for every word the sink takes.

When the running count reaches the expected length, the loader stops feeding. It then waits for the targets to report that they are configured. An error code from the targets, or a missing done indication within a fixed number of cycles, ends the load early. In every case the loader raises a level interrupt, and that interrupt stays up until the host switches the engine off. In DMA-feed mode the loader requests one fixed-size block at a time from an external DMA engine. A separate control bit drives a reset level to the targets, so the host can pulse it with two writes.

Top module: `cfg_loader`

## Requirements
- R1: After reset, irq, dma_req, cfg_valid and tgt_reset are 0. Status, FIFO-used, total and current byte count all read 0, and FIFO-size reads FIFO_WORDS*4 (512 by default).
- R2: While control bit 0 (enable) is clear, writes to the FIFO window (0x3000) are dropped, and FIFO-used (0x4C) stays 0.
- R3: A write to the total byte count (0x50) takes effect only while the engine is disabled. While the engine is enabled, the write is ignored and the old value reads back.
- R4: Words reach cfg_data in the order they were written. Each word the sink accepts adds 4 to the current byte count (0x54). FIFO-used reports the FIFO occupancy in bytes.
- R5: Once the current count reaches the total, cfg_valid stays low even if words remain in the FIFO.
- R6: After the total is reached, a high tgt_done sets irq on the next clock edge. Status (0x44) bit 0 mirrors irq, and bit 18 mirrors tgt_done.
- R7: If tgt_done does not arrive within DONE_LIMIT cycles of reaching the total, status bit 1 is set and irq rises.
- R8: A nonzero tgt_err while loading is ORed into status bits [15:2], with tgt_err bit 0 landing in status bit 2. It stops further draining and raises irq. A word accepted in the same cycle is still counted.
- R9: Writing control (0x40) with bit 0 clear lowers irq and empties the FIFO. Writing it with bit 0 set while the engine is disabled clears the current count and all error bits.
- R10: tgt_reset follows control bit 1, so writing 0x3 and then 0x0 gives one reset pulse.
- R11: With control bits 0 and 2 set, dma_req rises when no block is pending and the FIFO has room for DMA_BLOCK_BYTES. dma_ack drops it, and it stays low until DMA_BLOCK_BYTES/4 words have been written and there is room again.
- R12: A FIFO write while the FIFO is full is dropped, and FIFO-used stays at capacity.
- R13: Enabling with a total of 0 skips feeding and goes straight to waiting for tgt_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register or FIFO-window write strobe |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_data | output | 32 | Word toward the configuration port |
| cfg_valid | output | 1 | cfg_data is valid |
| cfg_ready | input | 1 | Configuration port takes the word |
| tgt_done | input | 1 | Targets report configuration done |
| tgt_err | input | 14 | Target error code, nonzero on error |
| tgt_reset | output | 1 | Reset/deconfigure level to the targets |
| dma_req | output | 1 | Request for one DMA block |
| dma_ack | input | 1 | DMA engine accepted the request |
| irq | output | 1 | Load finished or failed |

## Verification
Two events can fall in the same clock edge: the sink accepting the final word of the image, and the targets presenting an error code. The bench holds one word in the FIFO with the sink stalled. It then raises cfg_ready and tgt_err together for a single cycle. The expected result is a current count that includes that word, the error latched with irq up, and no timeout bit, because the error must stop the load before the wait for done begins. A FIFO push that meets a pop in the same cycle is also exercised, by streaming words into an always-ready sink.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // Register offsets; software depends on these exact positions.
    localparam logic [13:0] OFF_CTRL   = 14'h0040;
    localparam logic [13:0] OFF_STATUS = 14'h0044;
    localparam logic [13:0] OFF_SIZE   = 14'h0048;
    localparam logic [13:0] OFF_USED   = 14'h004C;
    localparam logic [13:0] OFF_TOTAL  = 14'h0050;
    localparam logic [13:0] OFF_CUR    = 14'h0054;
    localparam logic [13:0] OFF_FIFO   = 14'h3000;

    // Control bit positions.
    localparam int CTRL_EN  = 0;
    localparam int CTRL_RST = 1;
    localparam int CTRL_DMA = 2;

    // Error field occupies status [15:1]; bit 1 is the done timeout,
    // [15:2] hold the latched target error code.
    localparam int TGT_ERR_W  = 14;
    localparam int ERR_FIELD_W = TGT_ERR_W + 1;
    localparam int STAT_DONE  = 18;

    typedef enum logic [1:0] {
        LD_OFF  = 2'd0,
        LD_FEED = 2'd1,
        LD_WAIT = 2'd2,
        LD_END  = 2'd3
    } ld_state_e;

endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic                        pop,
    input  logic [WIDTH-1:0]            wdata,
    output logic [WIDTH-1:0]            rdata,
    output logic                        empty,
    output logic                        full,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign count = q.cnt;
    assign rdata = mem[q.rd];

    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        d = q;
        if (flush) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) d.wr = q.wr + PW'(1);
            if (do_pop)  d.rd = q.rd + PW'(1);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= wdata;
    end

endmodule

// File: rtl/cfg_dma_pacer.sv
module cfg_dma_pacer #(
    parameter int DEPTH       = 128,
    parameter int BLOCK_WORDS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active,
    input  logic                        push_ok,
    input  logic                        ack,
    input  logic [$clog2(DEPTH+1)-1:0]  free_words,
    output logic                        req
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int BW = $clog2(BLOCK_WORDS+1);

    typedef struct packed {
        logic          req;
        logic [BW-1:0] left;
    } pacer_regs_t;

    pacer_regs_t q, d;

    assign req = q.req;

    always_comb begin
        d = q;
        if (!active) begin
            d.req  = 1'b0;
            d.left = '0;
        end else if (q.req && ack) begin
            d.req  = 1'b0;
            d.left = BW'(BLOCK_WORDS);
        end else begin
            if (push_ok && q.left != '0) d.left = q.left - BW'(1);
            d.req = q.req || ((q.left == '0) && (free_words >= CW'(BLOCK_WORDS)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cfg_done_timer.sv
module cfg_done_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT+1);

    logic [TW-1:0] cnt_q, cnt_d;

    assign expired = run && (cnt_q == TW'(LIMIT));

    always_comb begin
        if (!run)                     cnt_d = '0;
        else if (cnt_q == TW'(LIMIT)) cnt_d = cnt_q;
        else                          cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int FIFO_WORDS      = 128,
    parameter int DMA_BLOCK_BYTES = 256,
    parameter int DONE_LIMIT      = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [13:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] cfg_data,
    output logic        cfg_valid,
    input  logic        cfg_ready,
    input  logic        tgt_done,
    input  logic [13:0] tgt_err,
    output logic        tgt_reset,
    output logic        dma_req,
    input  logic        dma_ack,
    output logic        irq
);
    localparam int BLOCK_WORDS = DMA_BLOCK_BYTES / 4;
    localparam int CW          = $clog2(FIFO_WORDS+1);

    typedef struct packed {
        ld_state_e              state;
        logic [2:0]             ctrl;
        logic [31:0]            total;
        logic [31:0]            cur;
        logic [ERR_FIELD_W-1:0] err;
        logic                   irq;
    } ld_regs_t;

    ld_regs_t q, d;

    logic          ctrl_wr, total_wr, fifo_wr, flush, accept;
    logic          fifo_empty, fifo_full, timer_exp, dma_active;
    logic [CW-1:0] fifo_cnt, free_words;
    logic [31:0]   status_word;

    assign ctrl_wr  = bus_wr && (bus_addr == OFF_CTRL);
    assign total_wr = bus_wr && (bus_addr == OFF_TOTAL);
    assign fifo_wr  = bus_wr && (bus_addr == OFF_FIFO) && (q.state != LD_OFF);
    assign flush    = ctrl_wr && !bus_wdata[CTRL_EN];

    assign cfg_valid = (q.state == LD_FEED) && !fifo_empty;
    assign accept    = cfg_valid && cfg_ready;

    assign free_words = CW'(FIFO_WORDS) - fifo_cnt;
    assign dma_active = q.ctrl[CTRL_EN] && q.ctrl[CTRL_DMA];

    cfg_fifo #(.WIDTH(32), .DEPTH(FIFO_WORDS)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (fifo_wr),
        .pop   (accept),
        .wdata (bus_wdata),
        .rdata (cfg_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    cfg_dma_pacer #(.DEPTH(FIFO_WORDS), .BLOCK_WORDS(BLOCK_WORDS)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (dma_active),
        .push_ok    (fifo_wr && !fifo_full),
        .ack        (dma_ack),
        .free_words (free_words),
        .req        (dma_req)
    );

    cfg_done_timer #(.LIMIT(DONE_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.state == LD_WAIT),
        .expired (timer_exp)
    );

    always_comb begin
        d = q;

        // Feed and completion sequencing.
        case (q.state)
            LD_FEED: begin
                if (accept) begin
                    d.cur = q.cur + 32'd4;
                    if (q.cur + 32'd4 >= q.total) d.state = LD_WAIT;
                end
            end
            LD_WAIT: begin
                if (tgt_done) begin
                    d.state = LD_END;
                    d.irq   = 1'b1;
                end else if (timer_exp) begin
                    d.err[0] = 1'b1;
                    d.state  = LD_END;
                    d.irq    = 1'b1;
                end
            end
            default: ;
        endcase

        // Target error: latch, stop draining, interrupt.
        if ((q.state == LD_FEED || q.state == LD_WAIT) && (tgt_err != '0)) begin
            d.err   = d.err | {tgt_err, 1'b0};
            d.state = LD_END;
            d.irq   = 1'b1;
        end

        // Total byte count is writable only while disabled.
        if (total_wr && !q.ctrl[CTRL_EN]) d.total = bus_wdata;

        // Control writes override the sequencer.
        if (ctrl_wr) begin
            d.ctrl = bus_wdata[2:0];
            if (!bus_wdata[CTRL_EN]) begin
                d.state = LD_OFF;
                d.irq   = 1'b0;
            end else if (!q.ctrl[CTRL_EN]) begin
                d.state = (q.total == '0) ? LD_WAIT : LD_FEED;
                d.cur   = '0;
                d.err   = '0;
                d.irq   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LD_OFF;
        end else begin
            q <= d;
        end
    end

    assign irq       = q.irq;
    assign tgt_reset = q.ctrl[CTRL_RST];

    always_comb begin
        status_word            = '0;
        status_word[0]         = q.irq;
        status_word[15:1]      = q.err;
        status_word[STAT_DONE] = tgt_done;
    end

    always_comb begin
        case (bus_addr)
            OFF_CTRL:   bus_rdata = {29'd0, q.ctrl};
            OFF_STATUS: bus_rdata = status_word;
            OFF_SIZE:   bus_rdata = 32'(FIFO_WORDS * 4);
            OFF_USED:   bus_rdata = 32'({fifo_cnt, 2'b00});
            OFF_TOTAL:  bus_rdata = q.total;
            OFF_CUR:    bus_rdata = q.cur;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_valid,
    input logic          cfg_ready,
    input logic [31:0]   cur,
    input logic [31:0]   total,
    input logic          irq,
    input logic          dma_req,
    input logic          dma_mode,
    input logic [CW-1:0] used_words,
    input logic          ctrl_wr,
    input logic          ctrl_en_bit,
    input logic          in_wait,
    input logic          tgt_done
);
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready) |=> (cur == $past(cur) + 32'd4));

    a_r5_stop_at_total: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cur < total));

    a_r8_halt_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !cfg_valid);

    a_r9_disable_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_en_bit) |=> !irq);

    a_r6_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && tgt_done && !ctrl_wr) |=> irq);

    a_r11_req_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> !dma_req);

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        used_words <= CW'(DEPTH));

endmodule

bind cfg_loader cfg_loader_chk #(.DEPTH(FIFO_WORDS), .CW($clog2(FIFO_WORDS+1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_ready   (cfg_ready),
    .cur         (q.cur),
    .total       (q.total),
    .irq         (irq),
    .dma_req     (dma_req),
    .dma_mode    (dma_active),
    .used_words  (fifo_cnt),
    .ctrl_wr     (ctrl_wr),
    .ctrl_en_bit (bus_wdata[0]),
    .in_wait     (q.state == cfg_loader_pkg::LD_WAIT),
    .tgt_done    (tgt_done)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
    localparam int DEPTH = 128;
    localparam int LIMIT = 200;

    localparam logic [13:0] A_CTRL = 14'h0040, A_STAT = 14'h0044, A_SIZE = 14'h0048,
                            A_USED = 14'h004C, A_TOT = 14'h0050, A_CUR = 14'h0054,
                            A_FIFO = 14'h3000;

    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, cfg_data;
    logic        cfg_valid, cfg_ready = 0, tgt_done = 0, tgt_reset, dma_req, dma_ack = 0, irq;
    logic [13:0] tgt_err = '0;

    int checks = 0, errors = 0;
    logic [31:0] exp_q [0:1023];
    int exp_wr = 0, exp_rd = 0;

    always #2.5 clk = ~clk;

    cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_data(cfg_data),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .tgt_done(tgt_done),
        .tgt_err(tgt_err), .tgt_reset(tgt_reset), .dma_req(dma_req),
        .dma_ack(dma_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bwrite(input logic [13:0] a, input logic [31:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic bread(input logic [13:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    // Word that the design is expected to forward.
    task automatic push_word(input logic [31:0] v);
        exp_q[exp_wr] = v; exp_wr++;
        bwrite(A_FIFO, v);
    endtask

    task automatic disable_engine();
        bwrite(A_CTRL, 32'h0);
        exp_rd = exp_wr;
    endtask

    // Scoreboard: compare accepted words in order (R4).
    always @(negedge clk) begin
        if (rst_n && cfg_valid && cfg_ready) begin
            check("R4 word order", cfg_data, exp_q[exp_rd]);
            exp_rd++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3); rst_n = 1; tick(1);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 dma_req", 32'(dma_req), 0);
        check("R1 cfg_valid", 32'(cfg_valid), 0);
        check("R1 tgt_reset", 32'(tgt_reset), 0);
        bread(A_STAT, v); check("R1 status", v, 0);
        bread(A_USED, v); check("R1 used", v, 0);
        bread(A_SIZE, v); check("R1 size", v, DEPTH*4);
        bread(A_TOT, v);  check("R1 total", v, 0);
        bread(A_CUR, v);  check("R1 cur", v, 0);

        // R2 writes while disabled are dropped
        bwrite(A_FIFO, 32'hDEAD0001); bwrite(A_FIFO, 32'hDEAD0002);
        bread(A_USED, v); check("R2 used while disabled", v, 0);

        // R3 total write ignored while enabled
        bwrite(A_TOT, 32);
        bwrite(A_CTRL, 32'h1);
        bwrite(A_TOT, 100);
        bread(A_TOT, v); check("R3 total locked", v, 32);

        // R4/R5 occupancy, counting, stop at total
        for (int i = 0; i < 10; i++) push_word(32'hA000_0000 + i);
        bread(A_USED, v); check("R4 used bytes", v, 40);
        cfg_ready = 1; tick(15);
        bread(A_CUR, v);  check("R4 cur bytes", v, 32);
        bread(A_USED, v); check("R5 leftover", v, 8);
        check("R5 valid low at total", 32'(cfg_valid), 0);
        check("R6 no irq before done", 32'(irq), 0);
        tgt_done = 1; tick(1);
        check("R6 irq after done", 32'(irq), 1);
        bread(A_STAT, v); check("R6 status done", v, 32'h0004_0001);
        tgt_done = 0;
        disable_engine();
        check("R9 irq cleared", 32'(irq), 0);
        bread(A_USED, v); check("R9 flushed", v, 0);

        // R4 streaming: push and pop in the same cycle
        bwrite(A_TOT, 16); bwrite(A_CTRL, 32'h1);
        for (int i = 0; i < 4; i++) push_word(32'hB100_0000 + 7*i);
        tick(4);
        bread(A_CUR, v); check("R4 streamed cur", v, 16);
        disable_engine(); cfg_ready = 0;

        // R7 done timeout, then R9 enable clears errors
        bwrite(A_TOT, 4); bwrite(A_CTRL, 32'h1);
        push_word(32'hC0C0_0001); cfg_ready = 1; tick(2); cfg_ready = 0;
        tick(LIMIT/2);
        check("R7 no irq mid-wait", 32'(irq), 0);
        tick(LIMIT/2 + 10);
        check("R7 irq on timeout", 32'(irq), 1);
        bread(A_STAT, v); check("R7 timeout bit", v, 32'h3);
        disable_engine(); bwrite(A_CTRL, 32'h1);
        bread(A_STAT, v); check("R9 errors cleared", v, 0);
        bread(A_CUR, v);  check("R9 cur cleared", v, 0);
        disable_engine();

        // R8 error halts draining
        bwrite(A_TOT, 64); bwrite(A_CTRL, 32'h1);
        for (int i = 0; i < 4; i++) push_word(32'hE000_0000 + i);
        tgt_err = 14'h5; tick(1); tgt_err = '0;
        check("R8 irq on error", 32'(irq), 1);
        bread(A_STAT, v); check("R8 error bits", v, 32'h15);
        cfg_ready = 1; tick(3);
        check("R8 draining halted", 32'(cfg_valid), 0);
        bread(A_CUR, v); check("R8 cur unchanged", v, 0);
        cfg_ready = 0; disable_engine();

        // R8 last word accepted in the same cycle as an error
        bwrite(A_TOT, 4); bwrite(A_CTRL, 32'h1);
        push_word(32'hF00D_0004);
        cfg_ready = 1; tgt_err = 14'h1; tick(1);
        cfg_ready = 0; tgt_err = '0; tick(1);
        bread(A_CUR, v);  check("R8 coincident cur", v, 4);
        bread(A_STAT, v); check("R8 coincident status", v, 32'h5);
        disable_engine();

        // R10 reset pulse
        bwrite(A_CTRL, 32'h3);
        check("R10 reset high", 32'(tgt_reset), 1);
        disable_engine();
        check("R10 reset low", 32'(tgt_reset), 0);

        // R11 DMA pacing, R12 overflow
        bwrite(A_TOT, 4096); bwrite(A_CTRL, 32'h5); tick(2);
        check("R11 req raised", 32'(dma_req), 1);
        dma_ack = 1; tick(1); dma_ack = 0;
        check("R11 req dropped on ack", 32'(dma_req), 0);
        for (int i = 0; i < 63; i++) bwrite(A_FIFO, 32'h1000 + i);
        tick(2);
        check("R11 req held during block", 32'(dma_req), 0);
        bwrite(A_FIFO, 32'h2000); tick(2);
        check("R11 req after block", 32'(dma_req), 1);
        dma_ack = 1; tick(1); dma_ack = 0;
        for (int i = 0; i < 64; i++) bwrite(A_FIFO, 32'h3000 + i);
        tick(2);
        check("R11 no req when full", 32'(dma_req), 0);
        bread(A_USED, v); check("R12 full", v, DEPTH*4);
        bwrite(A_FIFO, 32'h4000);
        bread(A_USED, v); check("R12 write dropped", v, DEPTH*4);
        exp_wr = exp_rd;
        disable_engine();

        // R13 zero total
        tgt_done = 1;
        bwrite(A_TOT, 0); bwrite(A_CTRL, 32'h1); tick(1);
        check("R13 irq with zero total", 32'(irq), 1);
        tgt_done = 0; disable_engine();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule